// File: doc/BRIEF.md
# Debug trace bank output multiplexer

This block brings internal design signals out to a narrow group of trace pins so that an external logic analyzer can observe them. Several equal-width signal banks are concatenated on one input vector. A run-time control word chooses which bank is visible, whether the pins carry bank data or an alignment pattern, and whether the trace output is active at all. A forwarded trace clock travels with the data so the analyzer can sample it.

Two parameters shape the pin interface. The first is the time-division rate: at 1x each pin carries one bank bit per design clock cycle. At 2x each pin carries two bits, one in each half of the cycle, so a bank is twice as wide as the pin group. The second is the capture mode: state mode registers the output word on the design clock, while timing mode sends the selected bank to the pins through logic alone. An alignment pattern (all ones, all zeros, then a one walking across the pins) lets the receiver measure per-pin skew. A build option lets the output come up already showing bank 0 after reset, with no command needed.

Top module: `trace_bank_mux`

## Requirements
- R1: Bank k occupies bits [k*W +: W] of `bank_in`, where W equals PINS at 1x and 2*PINS at 2x. BANKS must be 1, 2, 4, 8, 16, 32 or 64. When enabled in bank mode, the selected bank appears on the pins.
- R2: Only the selected bank reaches the pins. A change on any other bank has no effect on `trc_data`.
- R3: At 2x, while `clk` is high after a rising edge, the pins carry bits [PINS-1:0] of the output word. While `clk` is low, they carry bits [W-1:PINS].
- R4: `trc_clk` follows `clk` while the output is enabled. It is held low while the output is disabled or in reset.
- R5: In state mode, the output word is captured on the rising edge of `clk`. A bank change between edges first appears after the next rising edge.
- R6: In timing mode, the selected bank reaches the pins with no clock edge between the input change and the output.
- R7: In test mode, the output word follows a repeating sequence of length PINS+2. Step 0 puts all ones on every pin. Step 1 puts all zeros. Step 2+k sets only pin k. At 2x, both halves of the cycle carry the same pattern. Any control write restarts the sequence at step 0, and the sequence advances one step per cycle.
- R8: With ALWAYS_ON set, the block comes out of reset enabled in bank mode with bank 0 selected. No write is needed.
- R9: Without ALWAYS_ON, the pins read zero after reset until enable is written as 1. Writing enable as 0 returns the pins to zero one word later.
- R10: One strobe of `ctl_wr` loads the whole control byte on a rising edge: bit 7 is enable, bit 6 selects test mode, and bits 5:0 hold the bank index. The new setting governs the word captured on the following edge, so a change never splits a TDM pair.
- R11: A bank index of BANKS or more is loaded as 0.
- R12: With AUTO_SETUP cleared, bit 6 is ignored and the pins always carry bank data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock. Drives control loads, state capture and the half-cycle select |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_in | input | BANKS*W | All signal banks, concatenated with bank 0 in the low bits |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: enable, test mode, bank index |
| trc_clk | output | 1 | Forwarded trace clock |
| trc_data | output | PINS | Trace data pins |

## Verification
The hardest case to reach is a bank change that arrives in the middle of a design cycle at 2x. It must not reach the second half-word on the pins. The bench changes the selected bank just after the first half has been sampled. It then requires the second half to still show the word captured at the rising edge. A second instance is built in timing mode with always-on and with auto-setup off. It shows bank 0 straight out of reset, passes bank data with no edge, and ignores the test bit.

// File: rtl/trace_bank_mux.sv
`timescale 1ns/1ps
module trace_bank_mux #(
  parameter int BANKS      = 4,
  parameter int PINS       = 8,
  parameter bit TDM2       = 1'b1,
  parameter bit SYNC       = 1'b1,
  parameter bit ALWAYS_ON  = 1'b0,
  parameter bit AUTO_SETUP = 1'b1,
  localparam int W  = TDM2 ? 2*PINS : PINS,
  localparam int PW = $clog2(PINS+2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BANKS*W-1:0]   bank_in,
  input  logic                 ctl_wr,
  input  logic [7:0]           ctl_wdata,
  output logic                 trc_clk,
  output logic [PINS-1:0]      trc_data
);

  logic          en_q, tst_q;
  logic [5:0]    sel_q;
  logic [PW-1:0] pat_q;
  logic [PINS-1:0] pp;
  logic [W-1:0]  pat_word, bank_word, nxt_word, word;

  wire idx_ok = {1'b0, ctl_wdata[5:0]} < 7'(BANKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= ALWAYS_ON;
      tst_q <= 1'b0;
      sel_q <= '0;
    end else if (ctl_wr) begin
      en_q  <= ctl_wdata[7];
      tst_q <= AUTO_SETUP & ctl_wdata[6];
      sel_q <= idx_ok ? ctl_wdata[5:0] : 6'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pat_q <= '0;
    else if (ctl_wr)            pat_q <= '0;
    else if (en_q && tst_q)     pat_q <= (pat_q == PW'(PINS+1)) ? '0 : pat_q + PW'(1);
  end

  always_comb begin
    if (pat_q == '0)            pp = '1;
    else if (pat_q == PW'(1))   pp = '0;
    else                        pp = PINS'(1) << (pat_q - PW'(2));
  end

  generate
    if (TDM2) begin : g_pat2
      assign pat_word = {pp, pp};
    end else begin : g_pat1
      assign pat_word = pp;
    end
  endgenerate

  assign bank_word = bank_in[int'(sel_q)*W +: W];
  assign nxt_word  = !en_q ? '0 : (tst_q ? pat_word : bank_word);

  generate
    if (SYNC) begin : g_state
      logic [W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= nxt_word;
      end
      assign word = word_q;
    end else begin : g_timing
      assign word = nxt_word;
    end

    if (TDM2) begin : g_ddr
      assign trc_data = clk ? word[PINS-1:0] : word[W-1:PINS];
    end else begin : g_sdr
      assign trc_data = word;
    end
  endgenerate

  assign trc_clk = clk & en_q;

endmodule

// File: rtl/trace_bank_mux_chk.sv
`timescale 1ns/1ps
module trace_bank_mux_chk #(
  parameter int BANKS      = 4,
  parameter bit SYNC       = 1'b1,
  parameter bit AUTO_SETUP = 1'b1,
  parameter int PW         = 4,
  parameter int W          = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [7:0]    ctl_wdata,
  input logic          en_q,
  input logic          tst_q,
  input logic [5:0]    sel_q,
  input logic [PW-1:0] pat_q,
  input logic          trc_clk,
  input logic [W-1:0]  word
);

  // R10
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> en_q == $past(ctl_wdata[7]));

  // R12
  tst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> tst_q == (AUTO_SETUP && $past(ctl_wdata[6])));

  // R11
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ({1'b0, ctl_wdata[5:0]} >= 7'(BANKS))) |=> sel_q == 6'd0);

  // R7
  pat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> pat_q == '0);

  // R4
  trace_clk_chk: assert property (@(negedge clk) disable iff (!rst_n)
    trc_clk == en_q);

  generate
    if (SYNC) begin : g_s
      // R9
      idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_q) |-> word == '0);
    end else begin : g_t
      // R9
      idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> word == '0);
    end
  endgenerate

endmodule

bind trace_bank_mux trace_bank_mux_chk #(
  .BANKS(BANKS), .SYNC(SYNC), .AUTO_SETUP(AUTO_SETUP), .PW(PW), .W(W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .en_q(en_q), .tst_q(tst_q), .sel_q(sel_q), .pat_q(pat_q),
  .trc_clk(trc_clk), .word(word)
);

// File: tb/trace_bank_mux_test.sv
`timescale 1ns/1ps
module trace_bank_mux_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] bank_in = '0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        trc_clk;
  logic [7:0]  trc_data;

  logic [7:0]  bank_in2 = '0;
  logic        ctl_wr2 = 1'b0;
  logic [7:0]  ctl_wd2 = '0;
  logic        trc_clk2;
  logic [3:0]  trc_data2;

  trace_bank_mux uut (
    .clk(clk), .rst_n(rst_n), .bank_in(bank_in), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .trc_clk(trc_clk), .trc_data(trc_data));

  trace_bank_mux #(.BANKS(2), .PINS(4), .TDM2(1'b0), .SYNC(1'b0),
                   .ALWAYS_ON(1'b1), .AUTO_SETUP(1'b0)) uut_ao (
    .clk(clk), .rst_n(rst_n), .bank_in(bank_in2), .ctl_wr(ctl_wr2),
    .ctl_wdata(ctl_wd2), .trc_clk(trc_clk2), .trc_data(trc_data2));

  int vecs = 0, errs = 0;
  logic [15:0] exp_q[$];
  string       rid_q[$];

  logic       m_en = 1'b0, m_tst = 1'b0;
  int         m_sel = 0, m_pat = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] model_word();
    logic [7:0] p;
    if (!m_en) return 16'h0;
    if (m_tst) begin
      if (m_pat == 0)      p = 8'hFF;
      else if (m_pat == 1) p = 8'h00;
      else                 p = 8'h01 << (m_pat - 2);
      return {p, p};
    end
    return bank_in[m_sel*16 +: 16];
  endfunction

  // driver: one design cycle, expectation for the word captured at the next edge
  task automatic cycle(input logic wr, input logic [7:0] wd, input string r);
    @(negedge clk);
    ctl_wr = wr;
    ctl_wdata = wd;
    exp_q.push_back(model_word());
    rid_q.push_back(r);
    if (wr) begin
      m_en  = wd[7];
      m_tst = wd[6];
      m_sel = (int'(wd[5:0]) < 4) ? int'(wd[5:0]) : 0;
      m_pat = 0;
    end else if (m_en && m_tst) begin
      m_pat = (m_pat == 9) ? 0 : m_pat + 1;
    end
  endtask

  // monitor: low half while clk high, high half while clk low (R3)
  initial begin
    logic [15:0] e;
    string r;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = rid_q.pop_front();
        chk({r, "/R3 lo"}, trc_data, e[7:0]);
        @(negedge clk);
        #5;
        chk({r, "/R3 hi"}, trc_data, e[15:8]);
      end
    end
  end

  initial begin
    #(20 * 20000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R9 reset data", trc_data, 8'h00);
    chk("R4 reset clk", trc_clk, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    bank_in = {16'hDEF0, 16'h9ABC, 16'h5678, 16'h1234};
    bank_in2 = 8'h5A;
    #1;
    chk("R8 always-on bank0", trc_data2, 4'hA);
    @(posedge clk); #2;
    chk("R8 trace clk on", trc_clk2, 1'b1);
    bank_in2 = 8'h53;
    #1;
    chk("R6 timing pass-through", trc_data2, 4'h3);

    cycle(0, 8'h00, "R9");
    cycle(0, 8'h00, "R9");
    cycle(1, 8'h80, "R10");
    cycle(0, 8'h00, "R1");
    @(posedge clk); #5;
    chk("R4 clk high enabled", trc_clk, 1'b1);
    cycle(1, 8'h82, "R10");
    cycle(0, 8'h00, "R1");
    bank_in[16 +: 16] = 16'h0F0F;
    bank_in[48 +: 16] = 16'hF00F;
    cycle(0, 8'h00, "R2");
    cycle(0, 8'h00, "R2");
    cycle(1, 8'h81, "R1");
    cycle(0, 8'h00, "R1");
    // R5: change the selected bank after the low half is sampled
    @(posedge clk); #8;
    bank_in[16 +: 16] = 16'hC3A5;
    cycle(0, 8'h00, "R5");
    cycle(0, 8'h00, "R5");
    cycle(1, 8'h85, "R11");
    cycle(0, 8'h00, "R11");
    cycle(1, 8'hBF, "R11");
    cycle(0, 8'h00, "R11");
    cycle(1, 8'hC3, "R7");
    for (int i = 0; i < 12; i++) cycle(0, 8'h00, "R7");
    cycle(1, 8'hC0, "R7");
    cycle(0, 8'h00, "R7");
    cycle(0, 8'h00, "R7");
    cycle(1, 8'h02, "R9");
    cycle(0, 8'h00, "R9");
    cycle(0, 8'h00, "R9");
    @(posedge clk); #5;
    chk("R4 clk disabled", trc_clk, 1'b0);

    @(negedge clk);
    ctl_wr2 = 1'b1;
    ctl_wd2 = 8'hC1;
    @(negedge clk);
    ctl_wr2 = 1'b0;
    #1;
    chk("R12 test bit ignored", trc_data2, 4'h5);
    ctl_wd2 = 8'h00;
    @(negedge clk);
    ctl_wr2 = 1'b1;
    @(negedge clk);
    ctl_wr2 = 1'b0;
    #1;
    chk("R9 timing disabled", trc_data2, 4'h0);

    cycle(0, 8'h00, "R9");
    repeat (3) @(posedge clk);
    #15;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule